// File: doc/BRIEF.md
# Mode-Aware Load Extender and Right Shifter

This block is a 64-bit execution slice for a core that runs both older 32-bit programs and native 64-bit programs. A single mode input tells the slice which kind of program is running. Each accepted operation is either a load-data formatting step or a right shift. The slice returns one registered 64-bit result and a trap strobe one cycle after the operation is presented.

A 32-bit load value is widened to a full register in one of two ways. In 64-bit mode the value is sign extended. In 32-bit mode it is zero extended, so that older binaries see the register contents they expect. Each right shift carries its own operand width, 32 or 64 bits. The width sets the bit that the arithmetic fill copies and the modulus applied to the shift amount. Operations that exist only for 64-bit code are refused in 32-bit mode: they raise the trap strobe and return a zero result. Memory access, the register file and trap handling lie outside the block.

Top module: `modexec_slice`

## Requirements
- R1: While `rst_n` is low at a clock edge, the next outputs are `out_valid` = 0, `trap` = 0 and `result` = 0.
- R2: `out_valid` equals the value `in_valid` had at the previous clock edge. Every result is registered, so the latency is exactly one cycle.
- R3: Opcode 0 (word load) in 64-bit mode (`wide_mode` = 1) returns `ld_data[31:0]` sign extended from bit 31.
- R4: Opcode 0 (word load) in 32-bit mode (`wide_mode` = 0) returns `ld_data[31:0]` with the upper 32 bits forced to zero.
- R5: Opcode 1 (doubleword load) in 64-bit mode returns all 64 bits of `ld_data` unchanged.
- R6: Opcodes 4 (logical) and 5 (arithmetic) shift all 64 bits of `shf_src` right by `shf_amt` modulo 64. The logical shift fills with zeros. The arithmetic shift fills with bit 63.
- R7: Opcodes 2 (logical) and 3 (arithmetic) shift `shf_src[31:0]` right by `shf_amt[4:0]`. The logical shift fills with zeros and the arithmetic shift fills with bit 31. The upper 32 result bits are the sign extension of the 32-bit result in 64-bit mode and zero in 32-bit mode.
- R8: In 32-bit mode, opcodes 1, 4 and 5 are 64-bit-only. Each of them raises `trap` together with `out_valid`, and `result` is zero in that cycle.
- R9: Opcodes 6 and 7 are reserved. They raise `trap` with a zero `result` in either mode.
- R10: Any operation that is not covered by R8 or R9 returns `trap` = 0.
- R11: A cycle with `in_valid` low produces `out_valid` = 0 and `trap` = 0 at the next edge, and `result` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | An operation is presented this cycle |
| wide_mode | input | 1 | 1 = 64-bit mode, 0 = 32-bit mode |
| op | input | 3 | Opcode: 0 word load, 1 doubleword load, 2/3 32-bit logical/arithmetic right shift, 4/5 64-bit logical/arithmetic right shift, 6/7 reserved |
| ld_data | input | 64 | Load data; word loads use bits 31:0 |
| shf_src | input | 64 | Shift operand; 32-bit shifts use bits 31:0 |
| shf_amt | input | 6 | Shift amount |
| out_valid | output | 1 | Result of last cycle's operation is present |
| result | output | 64 | Registered 64-bit result |
| trap | output | 1 | Illegal-instruction strobe, coincident with out_valid |

## Verification
Two functions can act in the same cycle: the legality check and the datapath. The clearest case is a 64-bit shift or doubleword load in 32-bit mode. There the shifter produces a nonzero value, but the trap must force the result to zero. The sweep provokes this by running every opcode in both modes with every shift amount and with operands whose set bits would otherwise reach the result. Each such cycle is judged on both the strobe and a zero result. The mode also steers the extension of 32-bit shift results in the same cycle. That path is judged by comparing 32-bit shifts of negative operands across the two modes.

// File: rtl/mxs_pkg.sv
// Package: shared opcode encoding and default widths for the mode-aware slice.
// Assumes the opcode field is 3 bits wide; the values are part of the block's contract.
package mxs_pkg;

    localparam int XLEN_DEF = 64;

    typedef enum logic [2:0] {
        OP_LD_WORD  = 3'd0,
        OP_LD_DBL   = 3'd1,
        OP_SRL_WORD = 3'd2,
        OP_SRA_WORD = 3'd3,
        OP_SRL_DBL  = 3'd4,
        OP_SRA_DBL  = 3'd5,
        OP_RSV_6    = 3'd6,
        OP_RSV_7    = 3'd7
    } mxs_op_e;

    typedef struct packed {
        logic ld_word;
        logic ld_dbl;
        logic shift_word;
        logic shift_dbl;
        logic arith;
        logic illegal;
    } mxs_ctl_t;

endpackage

// File: rtl/mxs_decode.sv
// Module: opcode decoder and legality check.
// It classifies the opcode and marks an operation illegal when it is reserved,
// or when it is 64-bit-only and the core runs in 32-bit mode.
// Assumes the opcode values defined in mxs_pkg.
module mxs_decode
    import mxs_pkg::*;
(
    input  logic [2:0] op_i,
    input  logic       wide_i,
    output mxs_ctl_t   ctl_o
);

    mxs_op_e opc;
    logic    dbl_only;

    // Purpose: map the raw opcode onto the enum type
    always_comb opc = mxs_op_e'(op_i);

    // Purpose: decode the operation class and the fill rule
    always_comb begin
        ctl_o    = '0;
        dbl_only = 1'b0;
        case (opc)
            OP_LD_WORD:  ctl_o.ld_word = 1'b1;
            OP_LD_DBL: begin
                ctl_o.ld_dbl = 1'b1;
                dbl_only     = 1'b1;
            end
            OP_SRL_WORD: ctl_o.shift_word = 1'b1;
            OP_SRA_WORD: begin
                ctl_o.shift_word = 1'b1;
                ctl_o.arith      = 1'b1;
            end
            OP_SRL_DBL: begin
                ctl_o.shift_dbl = 1'b1;
                dbl_only        = 1'b1;
            end
            OP_SRA_DBL: begin
                ctl_o.shift_dbl = 1'b1;
                ctl_o.arith     = 1'b1;
                dbl_only        = 1'b1;
            end
            default:     ctl_o.illegal = 1'b1;
        endcase
        if (dbl_only && !wide_i) begin
            ctl_o.illegal = 1'b1;
        end
    end

endmodule

// File: rtl/mxs_rshift.sv
// Module: parameterized logarithmic right shifter.
// It shifts a W-bit value right by amt_i, filling with zeros or with the top bit.
// Assumes W is a power of two; amt_i is therefore taken modulo W.
module mxs_rshift #(
    parameter int W = 64,
    localparam int SW = $clog2(W)
) (
    input  logic [W-1:0]  data_i,
    input  logic [SW-1:0] amt_i,
    input  logic          arith_i,
    output logic [W-1:0]  data_o
);

    logic         fill;
    logic [W-1:0] stg [0:SW];

    // Purpose: choose the bit shifted in from the top
    always_comb fill = arith_i & data_i[W-1];

    // Purpose: feed the operand into the first stage
    always_comb stg[0] = data_i;

    for (genvar k = 0; k < SW; k++) begin : g_stage
        localparam int SH = 1 << k;
        // Purpose: conditionally shift by 2**k in this stage
        always_comb begin
            if (amt_i[k]) begin
                stg[k+1] = {{SH{fill}}, stg[k][W-1:SH]};
            end else begin
                stg[k+1] = stg[k];
            end
        end
    end

    // Purpose: present the last stage as the result
    always_comb data_o = stg[SW];

endmodule

// File: rtl/mxs_extend.sv
// Module: width extender.
// It widens a WI-bit value to WO bits, copying its top bit when sign_i is set
// and filling with zeros otherwise. Assumes WO > WI.
module mxs_extend #(
    parameter int WI = 32,
    parameter int WO = 64,
    localparam int WX = WO - WI
) (
    input  logic [WI-1:0] val_i,
    input  logic          sign_i,
    output logic [WO-1:0] val_o
);

    // Purpose: replicate the fill bit above the input value
    always_comb val_o = {{WX{sign_i & val_i[WI-1]}}, val_i};

endmodule

// File: rtl/modexec_slice.sv
// Module: mode-aware load extender and right shifter (top).
// It accepts one operation per cycle and registers a 64-bit result with a trap
// strobe. A 32-bit value is sign extended in 64-bit mode and zero extended in
// 32-bit mode. A trapping operation returns zero. Assumes XLEN is a power of two.
module modexec_slice
    import mxs_pkg::*;
#(
    parameter int XLEN = XLEN_DEF,
    localparam int HLEN = XLEN / 2,
    localparam int SW   = $clog2(XLEN),
    localparam int HSW  = $clog2(HLEN)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic            wide_mode,
    input  logic [2:0]      op,
    input  logic [XLEN-1:0] ld_data,
    input  logic [XLEN-1:0] shf_src,
    input  logic [SW-1:0]   shf_amt,
    output logic            out_valid,
    output logic [XLEN-1:0] result,
    output logic            trap
);

    mxs_ctl_t        ctl;
    logic [XLEN-1:0] sh_dbl;
    logic [HLEN-1:0] sh_word;
    logic [XLEN-1:0] sh_word_ext;
    logic [XLEN-1:0] ld_word_ext;
    logic [XLEN-1:0] nxt_result;

    mxs_decode u_dec (
        .op_i   (op),
        .wide_i (wide_mode),
        .ctl_o  (ctl)
    );

    mxs_rshift #(.W(XLEN)) u_sh_dbl (
        .data_i  (shf_src),
        .amt_i   (shf_amt),
        .arith_i (ctl.arith),
        .data_o  (sh_dbl)
    );

    mxs_rshift #(.W(HLEN)) u_sh_word (
        .data_i  (shf_src[HLEN-1:0]),
        .amt_i   (shf_amt[HSW-1:0]),
        .arith_i (ctl.arith),
        .data_o  (sh_word)
    );

    mxs_extend #(.WI(HLEN), .WO(XLEN)) u_ext_shift (
        .val_i  (sh_word),
        .sign_i (wide_mode),
        .val_o  (sh_word_ext)
    );

    mxs_extend #(.WI(HLEN), .WO(XLEN)) u_ext_load (
        .val_i  (ld_data[HLEN-1:0]),
        .sign_i (wide_mode),
        .val_o  (ld_word_ext)
    );

    // Purpose: select the datapath output; an illegal operation yields zero
    always_comb begin
        nxt_result = '0;
        if (!ctl.illegal) begin
            if (ctl.ld_word)    nxt_result = ld_word_ext;
            if (ctl.ld_dbl)     nxt_result = ld_data;
            if (ctl.shift_word) nxt_result = sh_word_ext;
            if (ctl.shift_dbl)  nxt_result = sh_dbl;
        end
    end

    // Purpose: register result, valid and trap strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            trap      <= 1'b0;
            result    <= '0;
        end else begin
            out_valid <= in_valid;
            trap      <= in_valid & ctl.illegal;
            if (in_valid) begin
                result <= nxt_result;
            end
        end
    end

endmodule

// File: rtl/mxs_slice_chk.sv
// Module: assertion checker for modexec_slice, attached by bind.
// It observes the ports only. Assumes the opcode encoding of mxs_pkg.
module mxs_slice_chk #(
    parameter int XLEN = 64,
    localparam int HLEN = XLEN / 2
) (
    input logic            clk,
    input logic            rst_n,
    input logic            in_valid,
    input logic            wide_mode,
    input logic [2:0]      op,
    input logic [XLEN-1:0] ld_data,
    input logic            out_valid,
    input logic [XLEN-1:0] result,
    input logic            trap
);

    a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && !trap));

    a_r11_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(result));

    a_r3_word_sign: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && wide_mode && op == 3'd0) |=>
            (result == {{HLEN{$past(ld_data[HLEN-1])}}, $past(ld_data[HLEN-1:0])}));

    a_r4_word_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !wide_mode && op == 3'd0) |=> (result[XLEN-1:HLEN] == '0));

    a_r8_narrow_trap: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !wide_mode && (op == 3'd1 || op == 3'd4 || op == 3'd5)) |=> trap);

    a_r9_reserved_trap: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op[2:1] == 2'b11) |=> trap);

    a_r8_trap_zero: assert property (@(posedge clk) disable iff (!rst_n)
        trap |-> (out_valid && result == '0));

    a_r10_wide_no_trap: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && wide_mode && op[2:1] != 2'b11) |=> !trap);

endmodule

bind modexec_slice mxs_slice_chk #(.XLEN(XLEN)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .wide_mode (wide_mode),
    .op        (op),
    .ld_data   (ld_data),
    .out_valid (out_valid),
    .result    (result),
    .trap      (trap)
);

// File: tb/tb_modexec_slice.sv
module tb_modexec_slice;

    localparam int CLK_PERIOD = 10;
    localparam int WDOG_LIMIT = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        wide_mode = 1'b0;
    logic [2:0]  op = '0;
    logic [63:0] ld_data = '0;
    logic [63:0] shf_src = '0;
    logic [5:0]  shf_amt = '0;
    logic        out_valid;
    logic [63:0] result;
    logic        trap;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit finished = 1'b0;

    modexec_slice dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .wide_mode (wide_mode),
        .op        (op),
        .ld_data   (ld_data),
        .shf_src   (shf_src),
        .shf_amt   (shf_amt),
        .out_valid (out_valid),
        .result    (result),
        .trap      (trap)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic string req_of(input logic [2:0] o, input logic w);
        if (o[2:1] == 2'b11)                        return "R9";
        if (!w && (o == 3'd1 || o == 3'd4 || o == 3'd5)) return "R8";
        case (o)
            3'd0:       return w ? "R3" : "R4";
            3'd1:       return "R5";
            3'd2, 3'd3: return "R7";
            default:    return "R6";
        endcase
    endfunction

    function automatic logic [64:0] model(input logic [2:0] o, input logic w,
                                          input logic [63:0] ld, input logic [63:0] src,
                                          input logic [5:0] amt);
        logic [31:0] r32;
        logic [63:0] r;
        logic        tr;
        tr = (o >= 3'd6) || (!w && (o == 3'd1 || o == 3'd4 || o == 3'd5));
        r  = '0;
        case (o)
            3'd0: r = w ? {{32{ld[31]}}, ld[31:0]} : {32'h0, ld[31:0]};
            3'd1: r = ld;
            3'd2, 3'd3: begin
                if (o == 3'd3) r32 = 32'($signed(src[31:0]) >>> amt[4:0]);
                else           r32 = src[31:0] >> amt[4:0];
                r = w ? {{32{r32[31]}}, r32} : {32'h0, r32};
            end
            3'd4: r = src >> amt;
            3'd5: r = 64'($signed(src) >>> amt);
            default: r = '0;
        endcase
        if (tr) r = '0;
        return {tr, r};
    endfunction

    task automatic check(input string req, input logic [64:0] act, input logic [64:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual trap/result %h expected %h", req, act, exp);
        end
    endtask

    task automatic run_op(input logic [2:0] o, input logic w, input logic [63:0] ld,
                          input logic [63:0] src, input logic [5:0] amt);
        logic [64:0] exp;
        @(negedge clk);
        in_valid  = 1'b1;
        wide_mode = w;
        op        = o;
        ld_data   = ld;
        shf_src   = src;
        shf_amt   = amt;
        exp       = model(o, w, ld, src, amt);
        @(negedge clk);
        check("R2", {64'h0, out_valid}, {64'h0, 1'b1});
        check(req_of(o, w), {trap, result}, exp);
        if (!exp[64]) check("R10", {64'h0, trap}, '0);
    endtask

    initial begin : wdog
        while (!finished) begin
            @(posedge clk);
            cycles++;
            if (cycles > WDOG_LIMIT) begin
                errors++;
                checks++;
                $display("FAIL watchdog: actual %0d cycles expected < %0d", cycles, WDOG_LIMIT);
                $display("Simulation finished: %0d checks, %0d errors", checks, errors);
                $finish;
            end
        end
    end

    initial begin : stim
        logic [63:0] pats [0:3];
        logic [63:0] held;
        pats[0] = 64'h8000_0001_8000_0001;
        pats[1] = 64'hFEDC_BA98_7654_3210;
        pats[2] = 64'h7FFF_FFFF_7FFF_FFFF;
        pats[3] = 64'h0123_4567_89AB_CDEF;

        repeat (3) @(negedge clk);
        // R1: outputs cleared during reset
        check("R1", {out_valid, result, trap}, '0);
        rst_n = 1'b1;

        for (int m = 0; m < 2; m++) begin
            for (int o = 0; o < 8; o++) begin
                for (int p = 0; p < 4; p++) begin
                    for (int a = 0; a < 64; a++) begin
                        run_op(3'(o), m[0], pats[p] ^ {58'h0, 6'(a)},
                               pats[(p + 1) % 4] ^ {a[5:0], 58'h0}, 6'(a));
                    end
                end
            end
        end

        // R7: mode steers the upper bits of a negative 32-bit shift result
        run_op(3'd2, 1'b1, '0, 64'h0000_0000_8000_0000, 6'd0);
        check("R7", {1'b0, result}, {1'b0, 64'hFFFF_FFFF_8000_0000});
        run_op(3'd2, 1'b0, '0, 64'h0000_0000_8000_0000, 6'd0);
        check("R7", {1'b0, result}, {1'b0, 64'h0000_0000_8000_0000});

        // R11: idle cycle keeps result and lowers valid and trap
        run_op(3'd1, 1'b1, 64'hA5A5_5A5A_0F0F_F0F0, '0, '0);
        held = result;
        @(negedge clk);
        in_valid  = 1'b0;
        op        = 3'd7;
        ld_data   = '0;
        @(negedge clk);
        check("R11", {out_valid, trap, result[62:0]}, {1'b0, 1'b0, held[62:0]});
        check("R11", {64'h0, result[63]}, {64'h0, held[63]});

        // R1: reset in mid-run clears outputs again
        run_op(3'd7, 1'b1, '0, '0, '0);
        @(negedge clk);
        rst_n    = 1'b0;
        in_valid = 1'b1;
        @(negedge clk);
        check("R1", {out_valid, result, trap}, '0);
        rst_n    = 1'b1;
        in_valid = 1'b0;
        @(negedge clk);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule